// File: doc/BRIEF.md
# Three-Backplane Multiplexed LCD Segment Driver

This block turns a latched map of display segments into the drive codes for a liquid crystal panel with three common backplanes. The panel holds four and a half digits with decimal points, a minus sign and two status flags. Every segment output line serves three segments, one for each backplane. Time multiplexing at one-third duty shows each of them in turn. The outputs are two-bit level codes that an analog stage outside this block turns into voltages. The codes are 00 for the display rail, 01 for the low intermediate level, 10 for the high intermediate level and 11 for the top supply.

A drive period lasts `DIV` oscillator clocks. It has two half-periods of opposite polarity, and each half-period has three equal slots, one per backplane. The annunciator output is a square wave at the period rate. A flag segment wired to it is lit, and a flag segment wired to its own backplane stays dark. Segment data is taken in only at the start of a period, so each period shows one consistent image with no net DC on any segment.

The map has twelve lines of three bits. For digit d (0 to 3), line 3d holds {A, G, D}, line 3d+1 holds {B, C, extra} and line 3d+2 holds {F, E, DP}, in backplane order 0, 1, 2. The extra slots carry the continuity flag (digit 0), low battery (digit 1), the minus sign (digit 2) and the leading half-digit "1" (digit 3).

Top module: `lcd_tri_drive`

## Requirements
- R1: While rst_ni is low, every backplane code, segment code and the annunciator code is 00. This takes effect at once, without waiting for a clock edge.
- R2: A clock edge that samples en_i low clears the timing and drives every output code to 00 from that edge. The first edge that samples en_i high again starts a new period at slot 0 with positive polarity.
- R3: Each slot lasts DIV/6 clocks, and the active backplane steps 0, 1, 2 and then repeats. Backplane b sits at bits [2b+1:2b] of bp_o.
- R4: In positive polarity the active backplane is 11 and the others are 01. In negative polarity the active backplane is 00 and the others are 10. This holds for any segment data.
- R5: Segment line L sits at bits [2L+1:2L] of seg_o. If its segment for the active backplane is on, the line is 00 in positive polarity and 11 in negative polarity. If that segment is off, the line is 10 in positive polarity and 01 in negative polarity.
- R6: Polarity is positive for the first DIV/2 clocks of a period and negative for the rest. ann_o is 11 in positive polarity and 00 in negative polarity.
- R7: map_i is captured only on the edge that starts a period. Changes at any other time have no effect until the next period. A change presented on that very edge is shown at once.
- R8: Bit L*3+b of map_i is the segment on line L for backplane b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Drive enable; low blanks all outputs |
| map_i | input | LINES*3 | Segment map, bit L*3+b = line L, backplane b |
| bp_o | output | 6 | Backplane level codes, 2 bits each |
| seg_o | output | LINES*2 | Segment line level codes, 2 bits each |
| ann_o | output | 2 | Annunciator square-wave level code |

## Verification
The risky overlap is between a new segment map and the period boundary. The bench presents a fresh map, or drops the enable, on exactly the edge where the last slot of negative polarity wraps. It also changes the map in mid-period. A behavioural model, keyed on the count of enabled clocks since the last restart, predicts which image and which polarity each cycle must show, and every output is compared against it on each cycle.

// File: rtl/lcd_tri_pkg.sv
package lcd_tri_pkg;
  typedef enum logic [1:0] {
    LVL_VDISP = 2'b00,
    LVL_VL    = 2'b01,
    LVL_VH    = 2'b10,
    LVL_VDD   = 2'b11
  } lvl_e;

  localparam int unsigned NUM_BP = 3;
  localparam int unsigned LVL_W  = 2;
endpackage

// File: rtl/lcd_tri_timer.sv
module lcd_tri_timer #(
  parameter int unsigned DIV = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  output logic       live_o,
  output logic [1:0] slot_o,
  output logic       pol_o,
  output logic       load_o
);
  localparam int unsigned SLOT_CYC = DIV / 6;
  localparam int unsigned CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic [1:0]    slot_q;
  logic          pol_q;
  logic          live_q;
  logic          last_cnt;
  logic          wrap;

  assign last_cnt = (cnt_q == CW'(SLOT_CYC - 1));
  assign wrap     = live_q && last_cnt && (slot_q == 2'd2) && pol_q;
  assign load_o   = en_i && (!live_q || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
      live_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
      live_q <= 1'b0;
    end else if (!live_q) begin
      live_q <= 1'b1;
    end else if (last_cnt) begin
      cnt_q <= '0;
      if (slot_q == 2'd2) begin
        slot_q <= '0;
        pol_q  <= ~pol_q;
      end else begin
        slot_q <= slot_q + 2'd1;
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign live_o = live_q;
  assign slot_o = slot_q;
  assign pol_o  = pol_q;

  p_slot_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q != 2'd3);

  p_slot_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && en_i && !last_cnt) |=> ($stable(slot_q) && $stable(pol_q)));

  p_pol_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && en_i && last_cnt && slot_q == 2'd2) |=> (pol_q != $past(pol_q)));
endmodule

// File: rtl/lcd_tri_bp.sv
module lcd_tri_bp
  import lcd_tri_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     live_i,
  input  logic [1:0]               slot_i,
  input  logic                     pol_i,
  output logic [NUM_BP*LVL_W-1:0]  bp_o,
  output logic [LVL_W-1:0]         ann_o
);
  logic [NUM_BP-1:0] extreme;

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    logic [LVL_W-1:0] code;
    always_comb begin
      if (!live_i)                   code = LVL_VDISP;
      else if (slot_i == 2'(b))      code = pol_i ? LVL_VDISP : LVL_VDD;
      else                           code = pol_i ? LVL_VH : LVL_VL;
    end
    assign bp_o[b*LVL_W +: LVL_W] = code;
    assign extreme[b] = (code == LVL_VDD) || (code == LVL_VDISP);
  end

  assign ann_o = (live_i && !pol_i) ? LVL_VDD : LVL_VDISP;

  p_one_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_i |-> $onehot(extreme));
endmodule

// File: rtl/lcd_tri_seg.sv
module lcd_tri_seg
  import lcd_tri_pkg::*;
#(
  parameter int unsigned LINES = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [LINES*NUM_BP-1:0]   map_i,
  input  logic                      live_i,
  input  logic [1:0]                slot_i,
  input  logic                      pol_i,
  output logic [LINES*LVL_W-1:0]    seg_o
);
  localparam int unsigned MW = LINES * NUM_BP;

  logic [MW-1:0] shown_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shown_q <= '0;
    else if (load_i) shown_q <= map_i;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic             on;
    logic [LVL_W-1:0] code;
    always_comb begin
      case (slot_i)
        2'd0:    on = shown_q[l*NUM_BP + 0];
        2'd1:    on = shown_q[l*NUM_BP + 1];
        default: on = shown_q[l*NUM_BP + 2];
      endcase
      if (!live_i)  code = LVL_VDISP;
      else if (on)  code = pol_i ? LVL_VDD : LVL_VDISP;
      else          code = pol_i ? LVL_VL : LVL_VH;
    end
    assign seg_o[l*LVL_W +: LVL_W] = code;
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shown_q));
endmodule

// File: rtl/lcd_tri_drive.sv
module lcd_tri_drive
  import lcd_tri_pkg::*;
#(
  parameter int unsigned DIV   = 1200,
  parameter int unsigned LINES = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [LINES*3-1:0]        map_i,
  output logic [5:0]                bp_o,
  output logic [LINES*2-1:0]        seg_o,
  output logic [1:0]                ann_o
);
  logic       live;
  logic [1:0] slot;
  logic       pol;
  logic       load;

  lcd_tri_timer #(.DIV(DIV)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .live_o (live),
    .slot_o (slot),
    .pol_o  (pol),
    .load_o (load)
  );

  lcd_tri_bp i_bp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_i (live),
    .slot_i (slot),
    .pol_i  (pol),
    .bp_o   (bp_o),
    .ann_o  (ann_o)
  );

  lcd_tri_seg #(.LINES(LINES)) i_seg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .map_i  (map_i),
    .live_i (live),
    .slot_i (slot),
    .pol_i  (pol),
    .seg_o  (seg_o)
  );

  p_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (bp_o == '0 && seg_o == '0 && ann_o == '0));

  p_ann_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ((ann_o == 2'b11) ==
              (bp_o[1:0] == 2'b11 || bp_o[3:2] == 2'b11 || bp_o[5:4] == 2'b11)));
endmodule

// File: tb/test_lcd_tri_drive.sv
`timescale 1ns/1ps
module test_lcd_tri_drive;
  localparam int DIV   = 12;
  localparam int LINES = 12;
  localparam int MW    = LINES * 3;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en = 1'b0;
  logic [MW-1:0]   map = '0;
  logic [5:0]      bp;
  logic [LINES*2-1:0] seg;
  logic [1:0]      ann;

  int      checks = 0;
  int      fails  = 0;
  bit      done   = 1'b0;
  int      m_k    = 0;
  bit      m_live = 1'b0;
  logic [MW-1:0] m_shown = '0;

  always #2.5 clk = ~clk;

  lcd_tri_drive #(.DIV(DIV), .LINES(LINES)) i_lcd_tri_drive (
    .clk_i (clk), .rst_ni (rst_ni), .en_i (en), .map_i (map),
    .bp_o (bp), .seg_o (seg), .ann_o (ann)
  );

  // behavioural model: count of enabled clocks since restart
  always @(posedge clk) begin
    if (!rst_ni || !en) begin
      m_live = 1'b0;
      m_k = 0;
    end else if (!m_live) begin
      m_live = 1'b1;
      m_k = 0;
      m_shown = map;
    end else begin
      m_k = (m_k + 1) % DIV;
      if (m_k == 0) m_shown = map;
    end
  end

  function automatic bit on_now();
    return rst_ni && m_live;
  endfunction
  function automatic bit m_pol();
    return m_k >= DIV / 2;
  endfunction
  function automatic int m_slot();
    return (m_k % (DIV / 2)) / (DIV / 6);
  endfunction

  function automatic logic [5:0] e_bp();
    logic [5:0] r = '0;
    if (!on_now()) return r;
    for (int b = 0; b < 3; b++) begin
      if (b == m_slot()) r[b*2 +: 2] = m_pol() ? 2'b00 : 2'b11;
      else               r[b*2 +: 2] = m_pol() ? 2'b10 : 2'b01;
    end
    return r;
  endfunction

  function automatic logic [LINES*2-1:0] e_seg();
    logic [LINES*2-1:0] r = '0;
    if (!on_now()) return r;
    for (int l = 0; l < LINES; l++) begin
      if (m_shown[l*3 + m_slot()]) r[l*2 +: 2] = m_pol() ? 2'b11 : 2'b00;
      else                         r[l*2 +: 2] = m_pol() ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  function automatic logic [1:0] e_ann();
    if (!on_now()) return 2'b00;
    return m_pol() ? 2'b00 : 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(on_now() ? "R4 backplane" : "R2 blank backplane", 64'(bp), 64'(e_bp()));
      chk(on_now() ? "R5 segment"   : "R2 blank segment",   64'(seg), 64'(e_seg()));
      chk(on_now() ? "R6 annunciator" : "R2 blank annunciator", 64'(ann), 64'(e_ann()));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic to_last();
    while (!(m_live && m_k == DIV - 1)) step(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    step(3);
    chk("R1 reset outputs", {bp, seg, ann}, '0);
    rst_ni = 1'b1;
    map = 36'h5A3C_96E1_7;
    en = 1'b1;
    step(1);
    chk("R3 R4 first slot backplanes", 64'(bp), 64'(6'b010111));
    step(DIV / 6);
    chk("R3 second slot backplanes", 64'(bp), 64'(6'b011101));
    // R8: single bit on line 4, backplane 1
    map = '0;
    map[4*3 + 1] = 1'b1;
    to_last();
    step(3);
    chk("R8 line 4 lit code", 64'(seg[9:8]), 64'(2'b00));
    chk("R8 line 3 dark code", 64'(seg[7:6]), 64'(2'b10));
    step(4);
    chk("R6 negative annunciator", 64'(ann), 64'(2'b00));
    chk("R6 negative active backplane", 64'(bp[1:0]), 64'(2'b00));
    chk("R6 negative idle backplane", 64'(bp[3:2]), 64'(2'b10));
    // R7: mid-period change ignored
    map = '1;
    step(1);
    chk("R7 mid-period change ignored", 64'(seg[9:8]), 64'(2'b01));
    // R7: change on the boundary edge shows at once
    to_last();
    map = '0;
    step(1);
    chk("R7 boundary change shown", 64'(seg), 64'(24'hAAAAAA));
    // mixed run with changes and enable drops on the boundary
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(0, 3) == 0) map = {$urandom_range(0, 15), $urandom()};
      if (m_live && m_k == DIV - 1 && $urandom_range(0, 5) == 0) en = 1'b0;
      else en = ($urandom_range(0, 40) != 0);
      step(1);
    end
    en = 1'b1;
    step(DIV + 2);
    en = 1'b0;
    step(1);
    chk("R2 disabled outputs", {bp, seg, ann}, '0);
    en = 1'b1;
    step(1);
    chk("R2 restart at slot 0", 64'(bp), 64'(6'b010111));
    step(5);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset outputs", {bp, seg, ann}, '0);
    step(2);
    rst_ni = 1'b1;
    step(2 * DIV);
    finish_run();
  end
endmodule